// File: doc/BRIEF.md
# Reference Clock Frequency Classifier

This block works out which of three telecom reference frequencies (19.44 MHz, 77.76 MHz or 155.52 MHz) is driving its reference input and turns the answer into divider settings for a clock-recovery loop. With those settings the loop can centre its oscillator without any strap pins or software set-up. The oscillator is taken to run at 622.08 MHz, which is an integer multiple of each supported reference. The feedback multiplier therefore depends only on the class that was detected. The output divider depends only on the line-rate select pin.

Measurement works as follows:

- The reference is first divided by `2**PRE_LOG2` in its own clock domain.
- That divided signal is carried into the measurement-clock domain through a synchronizer.
- Its rising edges are counted over a fixed window of `WIN_CYCLES` measurement-clock cycles.
- Each window count is compared against three guard bands. Each band is an expected count plus or minus `TOL`, all of them parameters.

A class is only reported once two windows in a row give the same result. An absent reference counts as "no valid reference", and so does one whose frequency falls outside every band. While no class is accepted, the divider outputs keep their last accepted values.

Top module: `refclass_top`

## Requirements
- R1: While rst_ni is low, and right after it rises, valid_o is 0, code_o is 0, fb_div_o is 0 and out_div_o is 0. A reset in mid-run returns the block to this state and starts classification again from scratch.
- R2: code_o encodes the class: 0 means no valid reference, 1 means 19.44 MHz, 2 means 77.76 MHz, 3 means 155.52 MHz. A window is placed in a class when its count of rising edges of the divided reference lies within TOL of that class's expected count.
- R3: valid_o rises only at the end of a window whose class is the same, and not 0, as the class of the window just before it. With the reference running from reset, valid_o is still 0 after 1.5 windows and is 1 after 2.5 windows.
- R4: If the reference stops toggling, code_o drops to 0 and valid_o to 0 within two windows.
- R5: A reference whose count lies outside every band gives code_o 0 and valid_o 0. fb_div_o and out_div_o keep the values they had before.
- R6: While valid_o is 1, fb_div_o becomes 32, 8 or 4 for codes 1, 2 and 3, one cycle later.
- R7: While valid_o is 1, out_div_o becomes 1 when rate_sel_i is 0 (622.08 Mb/s) and 4 when rate_sel_i is 1 (155.52 Mb/s), one cycle later.
- R8: While valid_o is 0, a change on rate_sel_i has no effect on out_div_o.
- R9: When the reference moves to another supported frequency, code_o and fb_div_o move to the new class within three windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock, known frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock under measurement |
| rate_sel_i | input | 1 | Line-rate select: 0 = 622.08 Mb/s, 1 = 155.52 Mb/s |
| code_o | output | 2 | Accepted reference class code |
| valid_o | output | 1 | Set when code_o is an accepted class |
| fb_div_o | output | FB_W | Oscillator feedback multiplier |
| out_div_o | output | OD_W | Oscillator-to-line-rate output divider |

## Verification
The hardest situations to reach from the ports are the ones at the edges of a window:

- a window that mixes two frequencies, because the reference changed partway through it;
- the stretch in which exactly one window has agreed.

The bench changes the reference frequency in the middle of a window and then samples at points chosen to lie safely between window boundaries, counted from the release of reset. At those points it checks that valid_o has not yet risen and that the divider outputs have held their values. It then returns later to confirm that the new class was adopted.

// File: rtl/refclass_pkg.sv
package refclass_pkg;
  localparam int NUM_REF = 3;
  typedef enum logic [1:0] {
    REF_NONE = 2'd0,
    REF_F19  = 2'd1,
    REF_F77  = 2'd2,
    REF_F155 = 2'd3
  } ref_code_e;
endpackage

// File: rtl/refclass_edge_cnt.sv
module refclass_edge_cnt #(
  parameter int PRE_LOG2   = 2,
  parameter int WIN_CYCLES = 1000,
  parameter int CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam int WIN_W = $clog2(WIN_CYCLES);

  logic [PRE_LOG2-1:0] pre_q;
  logic [2:0]          sync_q;
  logic [WIN_W-1:0]    win_q;
  logic [CNT_W-1:0]    acc_q;
  logic                rise;
  logic                last;

  // prescaler in the reference domain keeps the sampled rate low
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PRE_LOG2'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], pre_q[PRE_LOG2-1]};
  end

  assign rise = sync_q[1] & ~sync_q[2];
  assign last = (win_q == WIN_W'(WIN_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      acc_q  <= '0;
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else if (last) begin
      win_q  <= '0;
      acc_q  <= '0;
      cnt_o  <= acc_q + CNT_W'(rise);
      done_o <= 1'b1;
    end else begin
      win_q  <= win_q + WIN_W'(1);
      acc_q  <= acc_q + CNT_W'(rise);
      done_o <= 1'b0;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= CNT_W'(WIN_CYCLES / 2 + 1));

  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/refclass_decide.sv
module refclass_decide
  import refclass_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int EXP_F19  = 49,
  parameter int EXP_F77  = 194,
  parameter int EXP_F155 = 389,
  parameter int TOL      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             done_i,
  output ref_code_e        code_o,
  output logic             valid_o
);
  localparam int EXP_TAB [NUM_REF] = '{EXP_F19, EXP_F77, EXP_F155};

  logic [NUM_REF-1:0] hit;
  ref_code_e          code_now;
  ref_code_e          prev_q;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_band
    assign hit[g] = (int'(cnt_i) >= EXP_TAB[g] - TOL) &&
                    (int'(cnt_i) <= EXP_TAB[g] + TOL);
  end

  always_comb begin
    code_now = REF_NONE;
    for (int i = NUM_REF - 1; i >= 0; i--) begin
      if (hit[i]) code_now = ref_code_e'(2'(i + 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= REF_NONE;
      code_o  <= REF_NONE;
      valid_o <= 1'b0;
    end else if (done_i) begin
      prev_q <= code_now;
      if (code_now != REF_NONE && code_now == prev_q) begin
        code_o  <= code_now;
        valid_o <= 1'b1;
      end else begin
        code_o  <= REF_NONE;
        valid_o <= 1'b0;
      end
    end
  end

  p_valid_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> code_o != REF_NONE);

  p_rise_on_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(done_i));
endmodule

// File: rtl/refclass_div_map.sv
module refclass_div_map
  import refclass_pkg::*;
#(
  parameter int FB_W     = 6,
  parameter int OD_W     = 3,
  parameter int MUL_F19  = 32,
  parameter int MUL_F77  = 8,
  parameter int MUL_F155 = 4,
  parameter int OD_FAST  = 1,
  parameter int OD_SLOW  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ref_code_e       code_i,
  input  logic            valid_i,
  input  logic            rate_sel_i,
  output logic [FB_W-1:0] fb_div_o,
  output logic [OD_W-1:0] out_div_o
);
  logic [FB_W-1:0] mul_sel;

  always_comb begin
    unique case (code_i)
      REF_F19:  mul_sel = FB_W'(MUL_F19);
      REF_F77:  mul_sel = FB_W'(MUL_F77);
      REF_F155: mul_sel = FB_W'(MUL_F155);
      default:  mul_sel = fb_div_o;
    endcase
  end

  // dividers follow only an accepted class; otherwise hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_div_o  <= '0;
      out_div_o <= '0;
    end else if (valid_i) begin
      fb_div_o  <= mul_sel;
      out_div_o <= rate_sel_i ? OD_W'(OD_SLOW) : OD_W'(OD_FAST);
    end
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(fb_div_o) && $stable(out_div_o));
endmodule

// File: rtl/refclass_top.sv
module refclass_top
  import refclass_pkg::*;
#(
  parameter int PRE_LOG2   = 2,
  parameter int WIN_CYCLES = 1000,
  parameter int EXP_F19    = 49,
  parameter int EXP_F77    = 194,
  parameter int EXP_F155   = 389,
  parameter int TOL        = 4,
  parameter int FB_W       = 6,
  parameter int OD_W       = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_clk_i,
  input  logic            rate_sel_i,
  output logic [1:0]      code_o,
  output logic            valid_o,
  output logic [FB_W-1:0] fb_div_o,
  output logic [OD_W-1:0] out_div_o
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);

  logic [CNT_W-1:0] win_cnt;
  logic             win_done;
  ref_code_e        code_q;

  refclass_edge_cnt #(
    .PRE_LOG2  (PRE_LOG2),
    .WIN_CYCLES(WIN_CYCLES),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_clk_i(ref_clk_i),
    .cnt_o    (win_cnt),
    .done_o   (win_done)
  );

  refclass_decide #(
    .CNT_W   (CNT_W),
    .EXP_F19 (EXP_F19),
    .EXP_F77 (EXP_F77),
    .EXP_F155(EXP_F155),
    .TOL     (TOL)
  ) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (win_cnt),
    .done_i (win_done),
    .code_o (code_q),
    .valid_o(valid_o)
  );

  refclass_div_map #(
    .FB_W(FB_W),
    .OD_W(OD_W)
  ) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (code_q),
    .valid_i   (valid_o),
    .rate_sel_i(rate_sel_i),
    .fb_div_o  (fb_div_o),
    .out_div_o (out_div_o)
  );

  assign code_o = code_q;

  p_code_changes_on_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $past(win_done));
endmodule

// File: tb/sim_refclass_top.sv
module sim_refclass_top;
  localparam int CLK_PERIOD = 10000;
  localparam int H155 = 3215;
  localparam int H77  = 6430;
  localparam int H19  = 25720;
  localparam int HOOR = 10000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rate_sel = 1'b0;
  logic [1:0] code;
  logic       valid;
  logic [5:0] fb_div;
  logic [2:0] out_div;
  int         ref_half = H155;
  int         n_run = 0;
  int         n_fail = 0;

  refclass_top u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk),
    .rate_sel_i(rate_sel),
    .code_o    (code),
    .valid_o   (valid),
    .fb_div_o  (fb_div),
    .out_div_o (out_div)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      if (ref_half == 0) begin
        ref_clk = 1'b0;
        #(CLK_PERIOD);
      end else begin
        #(ref_half) ref_clk = ~ref_clk;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst_ni = 1'b0;
    wait_cyc(3);
    check("R1 valid", int'(valid), 0);
    check("R1 code", int'(code), 0);
    check("R1 fb_div", int'(fb_div), 0);
    check("R1 out_div", int'(out_div), 0);
    rst_ni = 1'b1;
  endtask

  // R3: needs two agreeing windows after reset
  task automatic t_first_lock(input int exp_code, input int exp_fb);
    wait_cyc(1500);
    check("R3 valid after 1.5 windows", int'(valid), 0);
    wait_cyc(1000);
    check("R3 valid after 2.5 windows", int'(valid), 1);
    check("R2 code", int'(code), exp_code);
    check("R6 fb_div", int'(fb_div), exp_fb);
  endtask

  task automatic t_rate(input logic sel, input int exp_od);
    rate_sel = sel;
    wait_cyc(3);
    check("R7 out_div", int'(out_div), exp_od);
  endtask

  task automatic t_switch(input int half, input int exp_code, input int exp_fb);
    wait_cyc(317);
    ref_half = half;
    wait_cyc(3500);
    check("R9 valid after change", int'(valid), 1);
    check("R9 code", int'(code), exp_code);
    check("R6 fb_div", int'(fb_div), exp_fb);
  endtask

  task automatic t_out_of_band(input int held_fb, input int held_od);
    wait_cyc(411);
    ref_half = HOOR;
    wait_cyc(2200);
    check("R5 valid", int'(valid), 0);
    check("R5 code", int'(code), 0);
    check("R5 fb_div held", int'(fb_div), held_fb);
    check("R5 out_div held", int'(out_div), held_od);
    rate_sel = ~rate_sel;
    wait_cyc(20);
    check("R8 out_div unaffected", int'(out_div), held_od);
  endtask

  task automatic t_absent(input int held_fb);
    wait_cyc(523);
    ref_half = 0;
    wait_cyc(2200);
    check("R4 valid", int'(valid), 0);
    check("R4 code", int'(code), 0);
    check("R4 fb_div held", int'(fb_div), held_fb);
  endtask

  task automatic t_mid_reset();
    ref_half = H155;
    wait_cyc(3500);
    check("R2 code before reset", int'(code), 3);
    @(negedge clk);
    rst_ni = 1'b0;
    wait_cyc(2);
    check("R1 valid in reset", int'(valid), 0);
    check("R1 fb_div in reset", int'(fb_div), 0);
    rst_ni = 1'b1;
    t_first_lock(3, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_first_lock(3, 4);
    t_rate(1'b0, 1);
    t_rate(1'b1, 4);
    t_switch(H77, 2, 8);
    t_switch(H19, 1, 32);
    t_out_of_band(32, 4);
    rate_sel = 1'b0;
    t_switch(H77, 2, 8);
    check("R7 out_div rate 0", int'(out_div), 1);
    t_absent(8);
    t_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule